// File: doc/BRIEF.md
# Intel HEX record loader

The loader takes printable characters one at a time, each qualified by a single-cycle valid strobe, and parses them as Intel HEX records. Each record starts with a colon, followed by pairs of hex digits. The pairs give the length byte, the two load-address bytes, the type byte, the data bytes and a final checksum byte. Every completed byte is added into a running 8-bit sum. The data bytes are collected in an internal 64-byte store. A record is judged only when its line ends on CR or LF. If the sum, the byte count and the type all agree, the stored bytes are written out as one burst on an external byte-wide memory bus. The burst uses a bus-request/grant handshake and an active-low write strobe that a wait input can stretch. A record that fails any test never reaches the bus.

The parser is a three-state machine:
- `PS_HUNT` waits for a colon, and is also where the parser sits after an error.
- `PS_BYTES` assembles nibbles into bytes.
- `PS_FLUSH` waits for the writer to finish a burst.

Its transitions are:
- colon: `PS_HUNT` to `PS_BYTES`.
- error raised: `PS_BYTES` to `PS_HUNT`.
- end of line on a good empty or end-of-file record: `PS_BYTES` to `PS_HUNT`.
- end of line on a good data record: `PS_BYTES` to `PS_FLUSH`.
- writer done: `PS_FLUSH` to `PS_HUNT`.

The writer is a second machine with three states:
- `WS_IDLE`: bus released.
- `WS_GRANT`: request held low, address and data driven, waiting for the grant.
- `WS_STROBE`: write strobe low until the wait input is high.

Its transitions are: start, `WS_IDLE` to `WS_GRANT`; grant low, `WS_GRANT` to `WS_STROBE`; wait high on a middle byte, `WS_STROBE` to `WS_GRANT`; wait high on the last byte, `WS_STROBE` to `WS_IDLE`.

Top module: `hexrec_loader`

## Requirements
- R1: A colon starts a record only while no record is open. A colon inside an open record sets `err_code` 2 (unexpected). A hex digit seen before any colon, while no error is pending, also sets code 2.
- R2: Space (0x20) and tab (0x09) between two bytes are ignored. Either of them between the two digits of one byte sets code 2.
- R3: Any character other than `0-9`, `A-F`, `a-f`, colon, space, tab, CR (0x0D) and LF (0x0A) sets code 1 (bad character).
- R4: At end of line, the 8-bit sum of every byte of the record, checksum included, must be 0x00; otherwise code 3.
- R5: Code 5 (bad length) is set when any of these holds at end of line: the count of data bytes differs from the length byte, more than 64 data bytes arrive, or the header and checksum are incomplete.
- R6: A type byte other than 0x00 (data) or 0x01 (end of file) sets code 4.
- R7: An accepted data record writes byte i to address load-address + i, modulo 2^16, in order. For each byte: `bus_req_n` is low, `wr_n` falls only after `bus_ack_n` was low, and `wr_n` stays low with address and data stable until `wait_n` is sampled high.
- R8: A record that raises any error causes no write, and `bus_req_n` stays high.
- R9: A record with length 0, or of type 0x01, is accepted with no bus activity.
- R10: An error sets `err`. Every character up to the next colon is discarded without changing `err_code`. That colon clears `err` and `err_code` to 0.
- R11: `line_no` increments once when CR and/or LF closes a line opened by a colon. `col_no` counts the characters taken since the last CR/LF, and CR/LF clears it.
- R12: `busy` is high from the end of line of an accepted data record until `rec_ok` pulses for one cycle with `err` low. Characters presented while `busy` is high are dropped.
- R13: After reset, the bus is released, `err` and `busy` are low, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| char_valid | input | 1 | `char_code` holds a new character this cycle |
| char_code | input | 8 | ASCII character |
| bus_req_n | output | 1 | Bus request, active low |
| bus_ack_n | input | 1 | Bus grant, active low |
| wr_n | output | 1 | Write strobe, active low |
| wait_n | input | 1 | Low stretches the write strobe |
| mem_addr | output | 16 | Write address |
| mem_data | output | 8 | Write data |
| busy | output | 1 | Burst in progress; characters are dropped |
| rec_ok | output | 1 | One-cycle pulse when a record is accepted |
| err | output | 1 | Error flag, held until the next colon |
| err_code | output | 3 | 0 ok, 1 bad char, 2 unexpected, 3 checksum, 4 type, 5 length |
| line_no | output | LINE_W | Lines closed since reset |
| col_no | output | COL_W | Characters since the last line end |

## Verification
The assertions guard the bus handshake on every cycle:
- the strobe falls only after a grant;
- address and data hold while the strobe is stretched;
- the request never appears outside a burst;
- `rec_ok` is a clean single pulse;
- `err` only rises on a character.

The bench is needed for everything that depends on what was sent: the error code chosen for each malformed record, the addresses and data bytes of each burst, and the line and column counts. It sweeps record lengths up to the full 64-byte store with varied grant delays, wait stretches, letter case and whitespace.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_BADCHAR = 3'd1,
        ERR_UNEXP   = 3'd2,
        ERR_CSUM    = 3'd3,
        ERR_TYPE    = 3'd4,
        ERR_LEN     = 3'd5
    } err_e;

    typedef enum logic [2:0] {
        CC_HEX,
        CC_COLON,
        CC_SPACE,
        CC_EOL,
        CC_OTHER
    } cclass_e;

    typedef enum logic [1:0] {
        PS_HUNT,
        PS_BYTES,
        PS_FLUSH
    } pstate_e;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_GRANT,
        WS_STROBE
    } wstate_e;

    localparam logic [7:0] REC_DATA = 8'h00;
    localparam logic [7:0] REC_EOF  = 8'h01;
    localparam int         HDR_BYTES = 4;

endpackage

// File: rtl/hexrec_char_class.sv
module hexrec_char_class
    import hexrec_pkg::*;
(
    input  logic [7:0] code,
    output cclass_e    cls,
    output logic [3:0] nib
);
    always_comb begin
        cls = CC_OTHER;
        nib = 4'h0;
        if (code >= 8'h30 && code <= 8'h39) begin
            cls = CC_HEX;
            nib = code[3:0];
        end else if ((code >= 8'h41 && code <= 8'h46) ||
                     (code >= 8'h61 && code <= 8'h66)) begin
            cls = CC_HEX;
            nib = code[3:0] + 4'd9;
        end else if (code == 8'h3A) begin
            cls = CC_COLON;
        end else if (code == 8'h20 || code == 8'h09) begin
            cls = CC_SPACE;
        end else if (code == 8'h0D || code == 8'h0A) begin
            cls = CC_EOL;
        end
    end
endmodule

// File: rtl/hexrec_byte_buf.sv
module hexrec_byte_buf #(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/hexrec_burst_wr.sv
module hexrec_burst_wr
    import hexrec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] base,
    input  logic [7:0]        rdata,
    output logic [IDX_W-1:0]  ridx,
    input  logic              bus_ack_n,
    input  logic              wait_n,
    output logic              bus_req_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        data,
    output logic              done
);
    wstate_e          ws_q, ws_d;
    logic [CNT_W-1:0] idx_q, idx_d;
    logic             done_d;
    logic             last;

    assign last = (idx_q == count - CNT_W'(1));

    // next-state process
    always_comb begin
        ws_d   = ws_q;
        idx_d  = idx_q;
        done_d = 1'b0;
        unique case (ws_q)
            WS_IDLE: begin
                if (start) begin
                    ws_d  = WS_GRANT;
                    idx_d = '0;
                end
            end
            WS_GRANT: begin
                if (!bus_ack_n) ws_d = WS_STROBE;
            end
            WS_STROBE: begin
                if (wait_n) begin
                    if (last) begin
                        ws_d   = WS_IDLE;
                        done_d = 1'b1;
                    end else begin
                        ws_d  = WS_GRANT;
                        idx_d = idx_q + CNT_W'(1);
                    end
                end
            end
            default: ws_d = WS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q  <= WS_IDLE;
            idx_q <= '0;
            done  <= 1'b0;
        end else begin
            ws_q  <= ws_d;
            idx_q <= idx_d;
            done  <= done_d;
        end
    end

    // output process
    always_comb begin
        bus_req_n = (ws_q == WS_IDLE);
        wr_n      = (ws_q != WS_STROBE);
        ridx      = idx_q[IDX_W-1:0];
        addr      = base + ADDR_W'(idx_q);
        data      = rdata;
    end

    assert_strobe_after_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> $past(!bus_ack_n));

    assert_hold_while_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !wait_n) |=> (!wr_n && $stable(addr) && $stable(data)));
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
    import hexrec_pkg::*;
#(
    parameter int BUF_DEPTH = 64,
    parameter int LINE_W    = 16,
    parameter int COL_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [7:0]        char_code,
    output logic              bus_req_n,
    input  logic              bus_ack_n,
    output logic              wr_n,
    input  logic              wait_n,
    output logic [15:0]       mem_addr,
    output logic [7:0]        mem_data,
    output logic              busy,
    output logic              rec_ok,
    output logic              err,
    output logic [2:0]        err_code,
    output logic [LINE_W-1:0] line_no,
    output logic [COL_W-1:0]  col_no
);
    localparam int ADDR_W = 16;
    localparam int IDX_W  = $clog2(BUF_DEPTH);
    localparam int CNT_W  = $clog2(BUF_DEPTH + 1);
    localparam int CMP_W  = (CNT_W > 8) ? CNT_W : 8;
    localparam int HDR_W  = $clog2(HDR_BYTES + 1);

    cclass_e    cls;
    logic [3:0] nib;

    hexrec_char_class u_class (
        .code (char_code),
        .cls  (cls),
        .nib  (nib)
    );

    pstate_e           st_q, st_d;
    logic              hi_q;
    logic [3:0]        nib_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [7:0]        len_q, type_q, sum_q, pend_q;
    logic [ADDR_W-1:0] base_q;
    logic              pend_v_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              err_q, open_q, start_q, ok_q;
    err_e              code_q;
    logic [LINE_W-1:0] line_q;
    logic [COL_W-1:0]  col_q;

    logic       raise, push, open_rec, burst, accept_now, finish, take;
    err_e       rcode;
    logic [7:0] byte_val;
    logic       wr_done;
    logic [7:0] rd_byte;
    logic [IDX_W-1:0] rd_idx;

    assign byte_val = {nib_q, nib};
    assign take     = char_valid && (st_q != PS_FLUSH);

    // next-state and event decode
    always_comb begin
        st_d       = st_q;
        raise      = 1'b0;
        rcode      = ERR_NONE;
        push       = 1'b0;
        open_rec   = 1'b0;
        burst      = 1'b0;
        accept_now = 1'b0;
        finish     = 1'b0;
        unique case (st_q)
            PS_HUNT: begin
                if (char_valid) begin
                    if (cls == CC_COLON) begin
                        open_rec = 1'b1;
                        st_d     = PS_BYTES;
                    end else if (cls == CC_HEX && !err_q) begin
                        raise = 1'b1;
                        rcode = ERR_UNEXP;
                    end else if (cls == CC_OTHER && !err_q) begin
                        raise = 1'b1;
                        rcode = ERR_BADCHAR;
                    end
                end
            end
            PS_BYTES: begin
                if (char_valid) begin
                    unique case (cls)
                        CC_HEX: begin
                            if (hi_q) begin
                                if (hdr_q == HDR_W'(HDR_BYTES - 1) &&
                                    byte_val != REC_DATA && byte_val != REC_EOF) begin
                                    raise = 1'b1;
                                    rcode = ERR_TYPE;
                                end else if (hdr_q == HDR_W'(HDR_BYTES) && pend_v_q) begin
                                    if (cnt_q == CNT_W'(BUF_DEPTH)) begin
                                        raise = 1'b1;
                                        rcode = ERR_LEN;
                                    end else begin
                                        push = 1'b1;
                                    end
                                end
                            end
                        end
                        CC_SPACE: begin
                            if (hi_q) begin
                                raise = 1'b1;
                                rcode = ERR_UNEXP;
                            end
                        end
                        CC_COLON: begin
                            raise = 1'b1;
                            rcode = ERR_UNEXP;
                        end
                        CC_OTHER: begin
                            raise = 1'b1;
                            rcode = ERR_BADCHAR;
                        end
                        CC_EOL: begin
                            if (hi_q) begin
                                raise = 1'b1;
                                rcode = ERR_UNEXP;
                            end else if (hdr_q != HDR_W'(HDR_BYTES) || !pend_v_q) begin
                                raise = 1'b1;
                                rcode = ERR_LEN;
                            end else if (sum_q != 8'h00) begin
                                raise = 1'b1;
                                rcode = ERR_CSUM;
                            end else if (CMP_W'(cnt_q) != CMP_W'(len_q)) begin
                                raise = 1'b1;
                                rcode = ERR_LEN;
                            end else if (type_q == REC_DATA && cnt_q != '0) begin
                                burst = 1'b1;
                            end else begin
                                accept_now = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                    if (raise || accept_now) st_d = PS_HUNT;
                    else if (burst)         st_d = PS_FLUSH;
                end
            end
            PS_FLUSH: begin
                if (wr_done) begin
                    finish = 1'b1;
                    st_d   = PS_HUNT;
                end
            end
            default: st_d = PS_HUNT;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= PS_HUNT;
            hi_q     <= 1'b0;
            nib_q    <= '0;
            hdr_q    <= '0;
            len_q    <= '0;
            type_q   <= '0;
            sum_q    <= '0;
            pend_q   <= '0;
            base_q   <= '0;
            pend_v_q <= 1'b0;
            cnt_q    <= '0;
            err_q    <= 1'b0;
            code_q   <= ERR_NONE;
            open_q   <= 1'b0;
            start_q  <= 1'b0;
            ok_q     <= 1'b0;
            line_q   <= '0;
            col_q    <= '0;
        end else begin
            st_q    <= st_d;
            start_q <= burst;
            ok_q    <= accept_now || finish;
            if (open_rec) begin
                hi_q     <= 1'b0;
                hdr_q    <= '0;
                sum_q    <= '0;
                pend_v_q <= 1'b0;
                cnt_q    <= '0;
                err_q    <= 1'b0;
                code_q   <= ERR_NONE;
            end
            if (char_valid && st_q == PS_BYTES && cls == CC_HEX) begin
                if (!hi_q) begin
                    hi_q  <= 1'b1;
                    nib_q <= nib;
                end else begin
                    hi_q  <= 1'b0;
                    sum_q <= sum_q + byte_val;
                    case (hdr_q)
                        HDR_W'(0): len_q          <= byte_val;
                        HDR_W'(1): base_q[15:8]   <= byte_val;
                        HDR_W'(2): base_q[7:0]    <= byte_val;
                        HDR_W'(3): type_q         <= byte_val;
                        default: begin
                            pend_q   <= byte_val;
                            pend_v_q <= 1'b1;
                        end
                    endcase
                    if (hdr_q != HDR_W'(HDR_BYTES)) hdr_q <= hdr_q + HDR_W'(1);
                    if (push) cnt_q <= cnt_q + CNT_W'(1);
                end
            end
            if (raise) begin
                err_q  <= 1'b1;
                code_q <= rcode;
            end
            if (take) begin
                if (cls == CC_EOL) begin
                    col_q  <= '0;
                    open_q <= 1'b0;
                    if (open_q) line_q <= line_q + LINE_W'(1);
                end else begin
                    col_q <= col_q + COL_W'(1);
                    if (open_rec) open_q <= 1'b1;
                end
            end
        end
    end

    hexrec_byte_buf #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_buf (
        .clk   (clk),
        .we    (push),
        .widx  (cnt_q[IDX_W-1:0]),
        .wdata (pend_q),
        .ridx  (rd_idx),
        .rdata (rd_byte)
    );

    hexrec_burst_wr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_q),
        .count     (cnt_q),
        .base      (base_q),
        .rdata     (rd_byte),
        .ridx      (rd_idx),
        .bus_ack_n (bus_ack_n),
        .wait_n    (wait_n),
        .bus_req_n (bus_req_n),
        .wr_n      (wr_n),
        .addr      (mem_addr),
        .data      (mem_data),
        .done      (wr_done)
    );

    // output process
    always_comb begin
        busy     = (st_q == PS_FLUSH);
        rec_ok   = ok_q;
        err      = err_q;
        err_code = code_q;
        line_no  = line_q;
        col_no   = col_q;
    end

    assert_bus_only_in_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req_n |-> busy);

    assert_ok_without_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ok |-> !err);

    assert_ok_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ok |=> !rec_ok);

    assert_err_on_char_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(char_valid));
endmodule

// File: tb/hexrec_loader_tb_top.sv
`timescale 1ns/1ps
module hexrec_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_valid = 1'b0;
    logic [7:0]  char_code = 8'h00;
    logic        bus_req_n, wr_n, busy, rec_ok, err;
    logic        bus_ack_n = 1'b1;
    logic        wait_n = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;
    logic [2:0]  err_code;
    logic [15:0] line_no;
    logic [7:0]  col_no;

    always #2 clk = ~clk;

    hexrec_loader dut_i (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_code(char_code),
        .bus_req_n(bus_req_n), .bus_ack_n(bus_ack_n), .wr_n(wr_n), .wait_n(wait_n),
        .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy), .rec_ok(rec_ok),
        .err(err), .err_code(err_code), .line_no(line_no), .col_no(col_no)
    );

    int n_chk = 0;
    int n_fail = 0;
    int ack_dly = 0, stall_len = 0, ack_cnt = 0, stall_cnt = 0;
    int nw = 0, n_ok = 0, ok0 = 0, exp_line = 0;
    logic [15:0] wa [128];
    logic [7:0]  wd [128];

    // bus partner model: grant after ack_dly cycles, stretch each strobe by stall_len
    always @(negedge clk) begin
        if (bus_req_n) begin
            ack_cnt = 0;
            bus_ack_n = 1'b1;
        end else if (ack_cnt >= ack_dly) begin
            bus_ack_n = 1'b0;
        end else begin
            ack_cnt++;
        end
        if (wr_n) begin
            stall_cnt = 0;
            wait_n = 1'b1;
        end else if (stall_cnt < stall_len) begin
            wait_n = 1'b0;
            stall_cnt++;
        end else begin
            wait_n = 1'b1;
            if (nw < 128) begin
                wa[nw] = mem_addr;
                wd[nw] = mem_data;
            end
            nw++;
        end
        if (rec_ok) n_ok++;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] hexch(input logic [3:0] n, input bit lower);
        if (n < 4'd10) return 8'h30 + 8'(n);
        return (lower ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
    endfunction

    function automatic logic [7:0] dbyte(input int seed, input int i);
        return 8'(seed * 13 + i * 29 + 7);
    endfunction

    task automatic send_raw(input logic [7:0] c);
        @(negedge clk);
        char_valid = 1'b1;
        char_code  = c;
        @(negedge clk);
        char_valid = 1'b0;
    endtask

    task automatic send_c(input logic [7:0] c);
        send_raw(c);
        while (busy) @(negedge clk);
    endtask

    task automatic send_hex(input logic [7:0] b, input bit lower);
        send_c(hexch(b[7:4], lower));
        send_c(hexch(b[3:0], lower));
    endtask

    task automatic send_rec(input int len_f, input logic [15:0] a, input logic [7:0] t,
                            input int nd, input int seed, input logic [7:0] cx,
                            input bit lower, input bit sp, input bit eol);
        logic [7:0] sum;
        nw = 0;
        ok0 = n_ok;
        sum = 8'(len_f) + a[15:8] + a[7:0] + t;
        send_c(8'h3A);
        send_hex(8'(len_f), lower);
        if (sp) send_c(8'h20);
        send_hex(a[15:8], lower);
        send_hex(a[7:0], lower);
        if (sp) send_c(8'h20);
        send_hex(t, lower);
        for (int i = 0; i < nd; i++) begin
            if (sp && (i % 2 == 1)) send_c(8'h09);
            send_hex(dbyte(seed, i), lower);
            sum = sum + dbyte(seed, i);
        end
        send_hex((8'h00 - sum) ^ cx, lower);
        if (eol) begin
            send_c(8'h0D);
            send_c(8'h0A);
            exp_line++;
        end
    endtask

    task automatic check_rec(input logic [2:0] ecode, input int ewr, input logic [15:0] a,
                             input int seed, input string tag);
        int bad;
        repeat (2) @(negedge clk);
        chk(err_code == ecode, tag, 32'(err_code), 32'(ecode));
        chk(nw == ewr, tag, 32'(nw), 32'(ewr));
        bad = 0;
        for (int i = 0; i < ewr && i < 128; i++)
            if (wa[i] != 16'(a + 16'(i)) || wd[i] != dbyte(seed, i)) bad++;
        chk(bad == 0, tag, 32'(bad), 32'd0);
        chk((n_ok - ok0) == ((ecode == 3'd0) ? 1 : 0), tag, 32'(n_ok - ok0),
            (ecode == 3'd0) ? 32'd1 : 32'd0);
    endtask

    bit done_flag = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lens [10];
        logic [15:0] a;
        lens = '{1, 2, 3, 4, 5, 8, 16, 31, 63, 64};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk(bus_req_n && wr_n, "R13", {30'd0, bus_req_n, wr_n}, 32'd3);
        chk(!err && err_code == 3'd0, "R13", 32'(err_code), 32'd0);
        chk(!busy && !rec_ok, "R13", {30'd0, busy, rec_ok}, 32'd0);
        chk(line_no == 16'd0 && col_no == 8'd0, "R13", 32'(line_no), 32'd0);

        // R7: sweep of lengths, addresses, grant delays, stretches, case and spacing
        for (int k = 0; k < 10; k++) begin
            a = (k == 3) ? 16'hFFFE : 16'(k * 16'h1357);
            ack_dly = k % 3;
            stall_len = (k + 1) % 4;
            send_rec(lens[k], a, 8'h00, lens[k], k, 8'h00, k[0], k[1], 1'b1);
            check_rec(3'd0, lens[k], a, k, "R7");
        end
        stall_len = 1;

        // R9: zero-length data record and end-of-file record
        send_rec(0, 16'h4000, 8'h00, 0, 1, 8'h00, 1'b0, 1'b0, 1'b1);
        check_rec(3'd0, 0, 16'h4000, 1, "R9");
        send_rec(0, 16'h0000, 8'h01, 0, 1, 8'h00, 1'b0, 1'b0, 1'b1);
        check_rec(3'd0, 0, 16'h0000, 1, "R9");

        // R4 and R8: bad checksum, nothing written
        send_rec(3, 16'h2000, 8'h00, 3, 5, 8'h01, 1'b0, 1'b0, 1'b1);
        check_rec(3'd3, 0, 16'h2000, 5, "R4");
        chk(err, "R8", 32'(err), 32'd1);

        // R6: unsupported type
        send_rec(2, 16'h3000, 8'h02, 2, 6, 8'h00, 1'b0, 1'b0, 1'b1);
        check_rec(3'd4, 0, 16'h3000, 6, "R6");

        // R5: count mismatch, then overflow beyond 64
        send_rec(3, 16'h5000, 8'h00, 2, 7, 8'h00, 1'b0, 1'b0, 1'b1);
        check_rec(3'd5, 0, 16'h5000, 7, "R5");
        send_rec(65, 16'h6000, 8'h00, 65, 8, 8'h00, 1'b0, 1'b0, 1'b1);
        check_rec(3'd5, 0, 16'h6000, 8, "R5");

        // R1: colon inside a record
        send_c(8'h3A); send_c(8'h30); send_c(8'h3A);
        chk(err && err_code == 3'd2, "R1", 32'(err_code), 32'd2);
        send_c(8'h0D); send_c(8'h0A); exp_line++;
        // R1: hex digit before any colon
        send_rec(0, 16'h0000, 8'h01, 0, 1, 8'h00, 1'b0, 1'b0, 1'b1);
        send_c(8'h35);
        chk(err && err_code == 3'd2, "R1", 32'(err_code), 32'd2);
        send_c(8'h0D); send_c(8'h0A);

        // R2: space between the digits of a byte
        send_rec(0, 16'h0000, 8'h01, 0, 1, 8'h00, 1'b0, 1'b0, 1'b1);
        send_c(8'h3A); send_c(8'h30); send_c(8'h20);
        chk(err && err_code == 3'd2, "R2", 32'(err_code), 32'd2);
        send_c(8'h0D); send_c(8'h0A); exp_line++;

        // R3: bad character
        send_rec(0, 16'h0000, 8'h01, 0, 1, 8'h00, 1'b0, 1'b0, 1'b1);
        send_c(8'h3A); send_c(8'h30); send_c(8'h47);
        chk(err && err_code == 3'd1, "R3", 32'(err_code), 32'd1);
        send_c(8'h0D); send_c(8'h0A); exp_line++;

        // R10: discard until colon, colon clears
        send_c(8'h39); send_c(8'h5A); send_c(8'h20); send_c(8'h3A - 8'h01);
        chk(err && err_code == 3'd1, "R10", 32'(err_code), 32'd1);
        send_c(8'h3A);
        chk(!err && err_code == 3'd0, "R10", 32'(err_code), 32'd0);
        send_c(8'h0D); send_c(8'h0A); exp_line++;
        chk(err_code == 3'd5, "R5", 32'(err_code), 32'd5);

        // R12: busy during burst, characters dropped
        stall_len = 3;
        send_rec(4, 16'h7000, 8'h00, 4, 9, 8'h00, 1'b0, 1'b0, 1'b0);
        send_raw(8'h0D); exp_line++;
        chk(busy, "R12", 32'(busy), 32'd1);
        send_raw(8'h47);
        while (busy) @(negedge clk);
        chk(!err && col_no == 8'd0, "R12", {24'd0, col_no}, 32'd0);
        check_rec(3'd0, 4, 16'h7000, 9, "R12");
        send_c(8'h0A);

        // R11: column and line counters
        send_c(8'h3A); send_c(8'h31); send_c(8'h32);
        chk(col_no == 8'd3, "R11", 32'(col_no), 32'd3);
        send_c(8'h0D); send_c(8'h0A); exp_line++;
        send_c(8'h3A); send_c(8'h0A); exp_line++;
        chk(col_no == 8'd0, "R11", 32'(col_no), 32'd0);
        chk(line_no == 16'(exp_line), "R11", 32'(line_no), 32'(exp_line));

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule